// File: doc/BRIEF.md
# Integer Flag Update Unit

This block sits behind a 64-bit integer ALU and turns one finished operation into architectural flag state. For each operation, marked by `valid`, it receives the operands, the result, an optional immediate and a set of enable bits. The first operand may arrive already marked for inversion. From these it derives the full-width and low-half carry and the full-width and low-half signed overflow. It accumulates a sticky summary-overflow bit and produces a 4-bit condition field that classifies the result.

All flag state is held in registers that load on the clock edge where `valid` is high. The new values are visible on the outputs from that edge onward. The ALU arithmetic and the divide-overflow detection are done upstream. A divide unit hands in its overflow verdict through `div_ov_present` and `div_ov`. An instruction that already wrote its own carry bits sets `done_mask` so that this block leaves those bits alone.

Top module: `flag_unit`

## Requirements
- R1: While `rst_n` is low, `ca`, `ca32`, `ov`, `ov32`, `so` and `cr_field` are all 0.
- R2: On a cycle with `valid` and `carry_en`, the carry result is 1 if any present operand, compared unsigned, exceeds `result`. The present operands are the effective first operand (`~op_a` when `inv_a`, else `op_a`), `op_b` when `b_present`, and `imm` when `imm_present`. Without `carry_en`, `ca` and `ca32` keep their values.
- R3: With `is_add` set, the low-half carry is `result[32] ^ a_eff[32] ^ s[32]`. Here `s` is `op_b` if `b_present`, else `imm` if `imm_present`, else 0.
- R4: With `is_add` clear, the low-half carry is 1 if the low 32 bits of any present operand are unsigned-greater than the low 32 bits of `result`.
- R5: `done_mask[0]` set keeps `ca` unchanged, and `done_mask[1]` set keeps `ca32` unchanged, even when `carry_en` is set.
- R6: When `valid`, `ov_en` and `ov_ok` are all set and a second operand `s` exists, `ov` is 1 exactly when `a_eff` and `s` have equal sign bits (bit 63) and the sign of `result` differs from them. `ov32` applies the same rule using bit 31.
- R7: When overflow is enabled and `div_ov_present` is set, both `ov` and `ov32` take the value of `div_ov`, whatever the operands are.
- R8: When overflow is enabled, `div_ov_present` is clear and neither `b_present` nor `imm_present` is set, `ov`, `ov32` and `so` keep their values.
- R9: Each overflow update ORs the new `ov` into `so`. Once set, `so` stays set until reset.
- R10: On a cycle with `valid` and `rc_en`, `cr_field` loads {negative, positive, zero, so} in bits 3 down to 0. The first three bits classify `result` as a signed number. Bit 0 is `so` after this operation's update. Without `rc_en`, `cr_field` is kept.
- R11: On a cycle with `valid` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | An operation is presented this cycle |
| is_add | input | 1 | Selects the add rule for the low-half carry |
| inv_a | input | 1 | Use the bitwise inverse of `op_a` |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second register operand |
| b_present | input | 1 | `op_b` takes part |
| imm | input | 64 | Immediate operand |
| imm_present | input | 1 | `imm` takes part |
| result | input | 64 | ALU result |
| carry_en | input | 1 | Update carry bits |
| ov_en | input | 1 | Overflow update requested |
| ov_ok | input | 1 | Overflow request is valid |
| div_ov_present | input | 1 | Divide-overflow verdict supplied |
| div_ov | input | 1 | Divide-overflow verdict |
| done_mask | input | 2 | Bit 0 protects `ca`, bit 1 protects `ca32` |
| rc_en | input | 1 | Write the condition field |
| ca | output | 1 | Full-width carry |
| ca32 | output | 1 | Low-half carry |
| ov | output | 1 | Full-width overflow |
| ov32 | output | 1 | Low-half overflow |
| so | output | 1 | Sticky summary overflow |
| cr_field | output | 4 | {negative, positive, zero, so} |

## Verification
The bench uses the default 64-bit width, which splits the word at bit 32 for the low-half flags. At that width, operands can be chosen so that the full-width and low-half carries disagree. Other operands make signed overflow occur only in the low half, or only at bit 63. A stimulus table also covers an immediate standing in for the second operand, an inverted first operand and a single-operand overflow request. Directed cases then check the priority of the divide verdict, the carry protection mask, the stickiness of `so` and the zero, positive and negative classes of the condition field.

// File: rtl/flag_pkg.sv
package flag_pkg;
  // Architectural flag state kept by the unit.
  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } flags_t;

  // Positions inside the 4-bit condition field; the order is consumed downstream.
  localparam int CR_NEG  = 3;
  localparam int CR_POS  = 2;
  localparam int CR_ZERO = 1;
  localparam int CR_SUM  = 0;
endpackage

// File: rtl/flag_carry.sv
module flag_carry #(
  parameter int W    = 64,
  parameter int NOPS = 3
) (
  input  logic [NOPS-1:0][W-1:0] ops,
  input  logic [NOPS-1:0]        present,
  input  logic [W-1:0]           first_op,
  input  logic [W-1:0]           second_op,
  input  logic [W-1:0]           result,
  input  logic                   is_add,
  output logic                   carry_full,
  output logic                   carry_half
);
  localparam int HALF = W / 2;

  logic [NOPS-1:0] gt_full;
  logic [NOPS-1:0] gt_half;

  // One unsigned comparator pair per operand slot.
  for (genvar i = 0; i < NOPS; i++) begin : g_cmp
    assign gt_full[i] = present[i] && (ops[i] > result);
    assign gt_half[i] = present[i] && (ops[i][HALF-1:0] > result[HALF-1:0]);
  end

  logic half_add;
  assign half_add = result[HALF] ^ first_op[HALF] ^ second_op[HALF];

  assign carry_full = |gt_full;
  assign carry_half = is_add ? half_add : (|gt_half);
endmodule

// File: rtl/flag_ovf.sv
module flag_ovf #(
  parameter int W = 64
) (
  input  logic [W-1:0] first_op,
  input  logic [W-1:0] second_op,
  input  logic [W-1:0] result,
  output logic         ovf_full,
  output logic         ovf_half
);
  localparam int HALF = W / 2;

  // Signed overflow: operands agree in sign, the result disagrees.
  assign ovf_full = (first_op[W-1] == second_op[W-1]) &&
                    (result[W-1] != first_op[W-1]);
  assign ovf_half = (first_op[HALF-1] == second_op[HALF-1]) &&
                    (result[HALF-1] != first_op[HALF-1]);
endmodule

// File: rtl/flag_cr.sv
module flag_cr #(
  parameter int W = 64
) (
  input  logic [W-1:0] result,
  input  logic         so_in,
  output logic [3:0]   field
);
  import flag_pkg::*;

  logic is_zero;
  assign is_zero = (result == '0);

  always_comb begin
    field           = '0;
    field[CR_NEG]   = result[W-1];
    field[CR_POS]   = !result[W-1] && !is_zero;
    field[CR_ZERO]  = is_zero;
    field[CR_SUM]   = so_in;
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         is_add,
  input  logic         inv_a,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         b_present,
  input  logic [W-1:0] imm,
  input  logic         imm_present,
  input  logic [W-1:0] result,
  input  logic         carry_en,
  input  logic         ov_en,
  input  logic         ov_ok,
  input  logic         div_ov_present,
  input  logic         div_ov,
  input  logic [1:0]   done_mask,
  input  logic         rc_en,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         ov32,
  output logic         so,
  output logic [3:0]   cr_field
);
  import flag_pkg::*;

  localparam int NOPS = 3;

  // Operand assembly: slot 0 first operand, slot 1 register, slot 2 immediate.
  logic [W-1:0]            a_eff;
  logic [W-1:0]            second;
  logic                    has_second;
  logic [NOPS-1:0][W-1:0]  ops;
  logic [NOPS-1:0]         present;

  assign a_eff      = inv_a ? ~op_a : op_a;
  assign has_second = b_present | imm_present;
  assign second     = b_present ? op_b : (imm_present ? imm : '0);
  assign ops        = {imm, op_b, a_eff};
  assign present    = {imm_present, b_present, 1'b1};

  logic c_full, c_half, o_full, o_half;

  flag_carry #(.W(W), .NOPS(NOPS)) u_carry (
    .ops        (ops),
    .present    (present),
    .first_op   (a_eff),
    .second_op  (second),
    .result     (result),
    .is_add     (is_add),
    .carry_full (c_full),
    .carry_half (c_half)
  );

  flag_ovf #(.W(W)) u_ovf (
    .first_op  (a_eff),
    .second_op (second),
    .result    (result),
    .ovf_full  (o_full),
    .ovf_half  (o_half)
  );

  flags_t     flags_q, flags_d;
  logic [3:0] cr_q, cr_d, cr_calc;

  flag_cr #(.W(W)) u_cr (
    .result (result),
    .so_in  (flags_d.so),
    .field  (cr_calc)
  );

  // Next-state logic.
  always_comb begin
    flags_d = flags_q;
    if (valid && carry_en) begin
      if (!done_mask[0]) flags_d.ca   = c_full;
      if (!done_mask[1]) flags_d.ca32 = c_half;
    end
    if (valid && ov_en && ov_ok) begin
      if (div_ov_present) begin
        flags_d.ov   = div_ov;
        flags_d.ov32 = div_ov;
        flags_d.so   = flags_q.so | div_ov;
      end else if (has_second) begin
        flags_d.ov   = o_full;
        flags_d.ov32 = o_half;
        flags_d.so   = flags_q.so | o_full;
      end
    end
  end

  assign cr_d = (valid && rc_en) ? cr_calc : cr_q;

  // Registers, loaded only when an operation is presented.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      cr_q    <= '0;
    end else if (valid) begin
      flags_q <= flags_d;
      cr_q    <= cr_d;
    end
  end

  assign ca       = flags_q.ca;
  assign ca32     = flags_q.ca32;
  assign ov       = flags_q.ov;
  assign ov32     = flags_q.ov32;
  assign so       = flags_q.so;
  assign cr_field = cr_q;
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid,
  input logic       b_present,
  input logic       imm_present,
  input logic       carry_en,
  input logic       ov_en,
  input logic       ov_ok,
  input logic       div_ov_present,
  input logic       div_ov,
  input logic [1:0] done_mask,
  input logic       rc_en,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       ov32,
  input logic       so,
  input logic [3:0] cr_field
);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable({ca, ca32, ov, ov32, so, cr_field}));

  a_r2_carry_off: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !carry_en) |=> $stable({ca, ca32}));

  a_r5_ca_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && done_mask[0]) |=> $stable(ca));

  a_r5_ca32_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && done_mask[1]) |=> $stable(ca32));

  a_r7_div_override: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ov_en && ov_ok && div_ov_present) |=>
      (ov == $past(div_ov)) && (ov32 == $past(div_ov)));

  a_r8_single_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ov_en && ov_ok && !div_ov_present && !b_present && !imm_present)
      |=> $stable({ov, ov32, so}));

  a_r9_so_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    so |=> so);

  a_r10_cr_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr_field[3:1]));

  a_r10_cr_so: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rc_en) |=> (cr_field[0] == so));
endmodule

bind flag_unit flag_unit_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .valid          (valid),
  .b_present      (b_present),
  .imm_present    (imm_present),
  .carry_en       (carry_en),
  .ov_en          (ov_en),
  .ov_ok          (ov_ok),
  .div_ov_present (div_ov_present),
  .div_ov         (div_ov),
  .done_mask      (done_mask),
  .rc_en          (rc_en),
  .ca             (ca),
  .ca32           (ca32),
  .ov             (ov),
  .ov32           (ov32),
  .so             (so),
  .cr_field       (cr_field)
);

// File: tb/flag_unit_tb.sv
module flag_unit_tb;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid, is_add, inv_a, b_present, imm_present;
  logic [W-1:0] op_a, op_b, imm, result;
  logic         carry_en, ov_en, ov_ok, div_ov_present, div_ov, rc_en;
  logic [1:0]   done_mask;
  logic         ca, ca32, ov, ov32, so;
  logic [3:0]   cr_field;

  always #2 clk = ~clk;

  flag_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .is_add(is_add), .inv_a(inv_a),
    .op_a(op_a), .op_b(op_b), .b_present(b_present), .imm(imm),
    .imm_present(imm_present), .result(result), .carry_en(carry_en),
    .ov_en(ov_en), .ov_ok(ov_ok), .div_ov_present(div_ov_present),
    .div_ov(div_ov), .done_mask(done_mask), .rc_en(rc_en),
    .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr_field(cr_field)
  );

  typedef struct packed {
    logic         add;
    logic         inv;
    logic [63:0]  a;
    logic [63:0]  b;
    logic         bp;
    logic [63:0]  im;
    logic         ip;
    logic [63:0]  res;
    logic [1:0]   mask;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h0, 2'b00},
    '{1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h8000_0000_0000_0000, 2'b00},
    '{1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h0000_0001_0000_0000, 2'b00},
    '{1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0, 1'b0, 64'h1, 1'b1, 64'h0000_0000_8000_0000, 2'b00},
    '{1'b0, 1'b1, 64'h5, 64'h9, 1'b1, 64'h0, 1'b0, 64'h4, 2'b00},
    '{1'b0, 1'b0, 64'h1234_5678_0000_0010, 64'h0000_0000_0000_0020, 1'b1, 64'h0, 1'b0, 64'h1234_5678_0000_0005, 2'b00},
    '{1'b0, 1'b0, 64'h0000_0000_0000_0003, 64'h0, 1'b0, 64'h0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 2'b00},
    '{1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1, 64'h0, 1'b0, 64'h0, 2'b01},
    '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 1'b1, 64'h3, 1'b1, 64'h1, 2'b10}
  };

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference state built from the requirements.
  logic m_ca, m_ca32, m_ov, m_ov32, m_so;
  logic [3:0] m_cr;

  task automatic check(input string tag, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "ca",   {3'b0, ca},   {3'b0, m_ca});
    check(tag, "ca32", {3'b0, ca32}, {3'b0, m_ca32});
    check(tag, "ov",   {3'b0, ov},   {3'b0, m_ov});
    check(tag, "ov32", {3'b0, ov32}, {3'b0, m_ov32});
    check(tag, "so",   {3'b0, so},   {3'b0, m_so});
    check(tag, "cr",   cr_field,     m_cr);
  endtask

  task automatic idle_inputs();
    valid = 0; is_add = 0; inv_a = 0; op_a = '0; op_b = '0; b_present = 0;
    imm = '0; imm_present = 0; result = '0; carry_en = 0; ov_en = 0; ov_ok = 0;
    div_ov_present = 0; div_ov = 0; done_mask = 2'b00; rc_en = 0;
  endtask

  // Model update: R2 R3 R4 R5 R6 R7 R8 R9 R10.
  task automatic model(input vec_t v, input logic ce, input logic oe, input logic ok,
                       input logic dvp, input logic dv, input logic rc);
    logic [63:0] ae, s;
    logic hs;
    ae = v.inv ? ~v.a : v.a;
    hs = v.bp | v.ip;
    s  = v.bp ? v.b : (v.ip ? v.im : 64'h0);
    if (ce) begin
      if (!v.mask[0])
        m_ca = (ae > v.res) || (v.bp && v.b > v.res) || (v.ip && v.im > v.res);
      if (!v.mask[1]) begin
        if (v.add) m_ca32 = v.res[32] ^ ae[32] ^ s[32];
        else m_ca32 = (ae[31:0] > v.res[31:0]) || (v.bp && v.b[31:0] > v.res[31:0]) ||
                      (v.ip && v.im[31:0] > v.res[31:0]);
      end
    end
    if (oe && ok) begin
      if (dvp) begin
        m_ov = dv; m_ov32 = dv; m_so = m_so | dv;
      end else if (hs) begin
        m_ov   = ($signed(ae) < 0) == ($signed(s) < 0) &&
                 ($signed(v.res) < 0) != ($signed(ae) < 0);
        m_ov32 = ($signed(ae[31:0]) < 0) == ($signed(s[31:0]) < 0) &&
                 ($signed(v.res[31:0]) < 0) != ($signed(ae[31:0]) < 0);
        m_so   = m_so | m_ov;
      end
    end
    if (rc) begin
      m_cr[3] = $signed(v.res) < 0;
      m_cr[2] = $signed(v.res) > 0;
      m_cr[1] = v.res == 0;
      m_cr[0] = m_so;
    end
  endtask

  task automatic apply(input vec_t v, input logic ce, input logic oe, input logic ok,
                       input logic dvp, input logic dv, input logic rc);
    @(negedge clk);
    valid = 1; is_add = v.add; inv_a = v.inv; op_a = v.a; op_b = v.b;
    b_present = v.bp; imm = v.im; imm_present = v.ip; result = v.res;
    carry_en = ce; ov_en = oe; ov_ok = ok; div_ov_present = dvp; div_ov = dv;
    done_mask = v.mask; rc_en = rc;
    model(v, ce, oe, ok, dvp, dv, rc);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    vec_t t;
    do_reset();
    check_all("R1");
    rst_n = 1;
    @(negedge clk);

    // Table walk: all updates enabled (R2 R3 R4 R5 R6 R9 R10).
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      check_all($sformatf("R2/R3/R4/R6 vec%0d", i));
    end

    // R9: so stays set after a clean operation.
    t = '{1'b1, 1'b0, 64'h1, 64'h1, 1'b1, 64'h0, 1'b0, 64'h2, 2'b00};
    apply(t, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R9", "so sticky", {3'b0, so}, 4'h1);
    check("R10", "cr positive", cr_field, 4'b0101);

    // R11: idle cycles change nothing.
    repeat (3) @(negedge clk);
    check_all("R11");

    // Fresh state for the directed cases.
    do_reset();
    rst_n = 1;
    @(negedge clk);

    // R6: overflow only in the low half.
    t = '{1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h0000_0000_8000_0000, 2'b00};
    apply(t, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    check("R6", "ov", {3'b0, ov}, 4'h0);
    check("R6", "ov32", {3'b0, ov32}, 4'h1);
    check("R9", "so from ov only", {3'b0, so}, 4'h0);

    // R7: divide verdict wins over operands that overflow.
    t = '{1'b1, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h8000_0000_0000_0000, 2'b00};
    apply(t, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", "ov", {3'b0, ov}, 4'h0);
    check("R7", "ov32", {3'b0, ov32}, 4'h0);
    apply(t, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R7", "ov set", {3'b0, ov}, 4'h1);
    check("R10", "cr negative with so", cr_field, 4'b1001);

    // R6 gating: ov_ok low leaves overflow alone.
    t = '{1'b1, 1'b0, 64'h1, 64'h1, 1'b1, 64'h0, 1'b0, 64'h2, 2'b00};
    apply(t, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6", "ov held without ok", {3'b0, ov}, 4'h1);

    // R8: single operand, overflow enabled, flags held.
    t = '{1'b1, 1'b0, 64'h1, 64'h0, 1'b0, 64'h0, 1'b0, 64'h2, 2'b00};
    apply(t, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R8", "ov held", {3'b0, ov}, 4'h1);
    check("R8", "ov32 held", {3'b0, ov32}, 4'h1);

    // R5: mask protects both carries; R2: carry_en off holds.
    t = '{1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 64'h0, 1'b0, 64'h0, 2'b11};
    apply(t, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", "ca masked", {3'b0, ca}, 4'h0);
    check("R5", "ca32 masked", {3'b0, ca32}, 4'h0);
    t.mask = 2'b00;
    apply(t, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2", "ca held without carry_en", {3'b0, ca}, 4'h0);
    apply(t, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R2", "ca set", {3'b0, ca}, 4'h1);
    check("R3", "ca32 add rule", {3'b0, ca32}, 4'h1);
    check("R10", "cr zero", cr_field, 4'b0011);

    finish_run();
  end
endmodule